// File: doc/BRIEF.md
# Real-time clock rate offset corrector

This block trims the rate of a real-time clock without touching its oscillator. It sits in the 64 Hz prescaler tick stream and adds or removes single ticks at fixed points in the hour. An 8-bit correction code selects how many ticks per hour change and in which direction. The code is held as a 7-bit signed count plus a coarse-mode flag. One tick changed every two hours trims the rate by about 2170 ppb. Coarse mode applies the same per-hour pattern in every hour rather than every second hour, so each step is twice as large.

All corrections for a minute are made during the first second of that minute, one per minute from minute 0 upward. The surplus of a magnitude above 60 goes into the last minute of the hour. The timekeeping counters supply the current minute, the current second and the parity of the hour. The code is sampled only when a new hour begins, so a write made during an hour first takes effect in the next hour.

Top module: `clkofs_corrector`

## Requirements
- R1: Code bit 7 selects coarse mode when 1. Bits 6:0 are a two's-complement count with its sign in bit 6. The magnitude m of that count ranges from 0 to 64, and a negative count means removal.
- R2: With bit 7 clear, corrections occur only in hours flagged even (`hour_odd` = 0). In odd hours no tick is added or removed.
- R3: With bit 7 set, corrections occur in every hour, odd or even.
- R4: For m up to 60, minute k (0..59) receives one correction when k < m and none otherwise.
- R5: For m above 60, minutes 0..58 receive one correction each and minute 59 receives m-59. No minute ever holds more than 5.
- R6: A positive count gives c corrections in a minute. For each of the first c input ticks of that minute's second 0, one extra output pulse is emitted in the cycle after the tick. The tick itself also passes.
- R7: A negative count gives c corrections in a minute. The first c input ticks of that minute's second 0 are suppressed, and later ticks pass.
- R8: Outside second 0, and in the cycle in which second 0 is entered, every input tick passes unchanged and no extra pulse is made.
- R9: The code and the hour parity are captured when the time enters minute 0, second 0. A code change made later in the hour does not affect that hour's corrections.
- R10: After reset the captured code is 0, so no correction occurs until the next hour start. The reset state also treats the time as already in second 0, and no extra pulse is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ofs_code | input | MAG_W+1 | Correction code: coarse flag on top, signed count below |
| hour_odd | input | 1 | 1 while the current hour is odd |
| minute | input | MIN_W | Current minute, binary 0..MINUTES-1 |
| second | input | SEC_W | Current second, binary |
| tick_in | input | 1 | Prescaler tick strobe, one cycle wide, at least two cycles apart |
| tick_out | output | 1 | Corrected tick strobe |

## Verification
The bench builds the block with its default parameters: a 7-bit signed count, 60 minutes per hour and 6-bit seconds. With these values the fold into the last minute is reachable, from magnitude 61 up to the most negative code, which gives 5 removals in minute 59. Random codes and hour parities over many hours exercise both modes in both parities. Directed hours cover codes 60 to 64, -1, -64 and coarse codes in odd hours. They also cover a mid-hour code change and the state left by reset.

// File: rtl/clkofs_corrector.sv
module clkofs_corrector #(
  parameter int MAG_W   = 7,
  parameter int MINUTES = 60,
  parameter int SEC_W   = 6,
  parameter int MIN_W   = $clog2(MINUTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAG_W:0]   ofs_code,
  input  logic             hour_odd,
  input  logic [MIN_W-1:0] minute,
  input  logic [SEC_W-1:0] second,
  input  logic             tick_in,
  output logic             tick_out
);

  localparam int LAST       = MINUTES - 1;
  localparam int CW         = (MAG_W > MIN_W ? MAG_W : MIN_W) + 1;
  localparam int MAX_BUDGET = (2**(MAG_W-1) > LAST) ? 2**(MAG_W-1) - LAST : 1;

  logic             sec0, sec0_q, start, new_hour;
  logic [MAG_W:0]   act_code, eff_code;
  logic             act_odd, eff_odd;
  logic             coarse, neg, active;
  logic [MAG_W-1:0] mag;
  logic [CW-1:0]    mag_w, min_w, load_cnt, budget;
  logic             dir_neg, extra_q, corr;

  assign sec0     = (second == '0);
  assign start    = sec0 && !sec0_q;
  assign new_hour = start && (minute == '0);

  assign eff_code = new_hour ? ofs_code : act_code;
  assign eff_odd  = new_hour ? hour_odd : act_odd;
  assign coarse   = eff_code[MAG_W];
  assign neg      = eff_code[MAG_W-1];
  assign active   = coarse || !eff_odd;
  assign mag      = neg ? (~eff_code[MAG_W-1:0] + MAG_W'(1)) : eff_code[MAG_W-1:0];
  assign mag_w    = CW'(mag);
  assign min_w    = CW'(minute);

  always_comb begin
    if (!active)
      load_cnt = '0;
    else if (min_w == CW'(LAST))
      load_cnt = (mag_w > CW'(LAST)) ? mag_w - CW'(LAST) : '0;
    else
      load_cnt = (mag_w > min_w) ? CW'(1) : '0;
  end

  assign corr     = sec0 && !start && tick_in && (budget != '0);
  assign tick_out = (tick_in && !(corr && dir_neg)) || extra_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec0_q   <= 1'b1;
      act_code <= '0;
      act_odd  <= 1'b0;
      budget   <= '0;
      dir_neg  <= 1'b0;
      extra_q  <= 1'b0;
    end else begin
      sec0_q  <= sec0;
      extra_q <= corr && !dir_neg;
      if (new_hour) begin
        act_code <= ofs_code;
        act_odd  <= hour_odd;
      end
      if (start) begin
        budget  <= load_cnt;
        dir_neg <= neg;
      end else if (!sec0) begin
        budget  <= '0;
      end else if (corr) begin
        budget  <= budget - CW'(1);
      end
    end
  end

  assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_in |=> !tick_in);

  assert_extra_follows_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    extra_q |-> ($past(tick_in) && !dir_neg));

  assert_drop_only_negative_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_in && !tick_out) |-> (dir_neg && sec0));

  assert_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec0 && !sec0_q) |-> (tick_out == tick_in));

  assert_budget_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    budget <= CW'(MAX_BUDGET));

  assert_budget_no_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (budget <= $past(budget)));

  assert_capture_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !new_hour |=> ($stable(act_code) && $stable(act_odd)));

endmodule

// File: tb/sim_clkofs_corrector.sv
module sim_clkofs_corrector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ofs_code = 8'h00;
  logic       hour_odd = 1'b0;
  logic [5:0] minute = 6'd0;
  logic [5:0] second = 6'd1;
  logic       tick_in = 1'b0;
  logic       tick_out;

  int n_chk = 0;
  int n_bad = 0;
  int outcnt = 0;
  int cycles = 0;
  bit done = 0;

  localparam int NTICK = 8;

  always #4 clk = ~clk;

  clkofs_corrector u0 (
    .clk(clk), .rst_n(rst_n), .ofs_code(ofs_code), .hour_odd(hour_odd),
    .minute(minute), .second(second), .tick_in(tick_in), .tick_out(tick_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic int exp_corr(input logic [7:0] code, input logic odd, input int k);
    int v, m;
    v = code[6] ? int'(code[6:0]) - 128 : int'(code[6:0]);
    m = (v < 0) ? -v : v;
    if (!code[7] && odd) return 0;
    if (k < 59) m = (m > k) ? 1 : 0;
    else        m = (m > 59) ? m - 59 : 0;
    return (v < 0) ? -m : m;
  endfunction

  function automatic string tag_of(input logic [7:0] code, input logic odd, input int k, input int e);
    if (odd && code[7])  return "R3";
    if (odd)             return "R2";
    if (k == 59)         return "R5";
    if (e > 0)           return "R6";
    if (e < 0)           return "R7";
    return "R4";
  endfunction

  task automatic check(input string req, input int got, input int exp, input string what);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic cyc(input logic t);
    @(negedge clk);
    tick_in = t;
    #1;
    if (tick_out) outcnt++;
  endtask

  task automatic ticks();
    for (int i = 0; i < NTICK; i++) begin
      cyc(1'b1); cyc(1'b0); cyc(1'b0);
    end
  endtask

  task automatic visit(input int k, input logic [7:0] cap, input logic odd_cap, input string req);
    int e;
    string t;
    e = exp_corr(cap, odd_cap, k);
    t = (req == "") ? tag_of(cap, odd_cap, k, e) : req;
    @(negedge clk);
    minute = 6'(k); second = 6'd0; tick_in = 1'b0;
    outcnt = 0;
    cyc(1'b0); cyc(1'b0);
    ticks();
    check(t, outcnt, NTICK + e, $sformatf("second 0 of minute %0d code %h odd %0b", k, cap, odd_cap));
    @(negedge clk);
    second = 6'd1;
    outcnt = 0;
    ticks();
    check("R8", outcnt, NTICK, $sformatf("second 1 of minute %0d", k));
  endtask

  task automatic new_hour(input logic [7:0] code, input logic odd, input string req);
    @(negedge clk);
    ofs_code = code; hour_odd = odd;
    visit(0, code, odd, req);
  endtask

  initial begin
    logic [7:0] c, c2;
    logic       o;
    void'($urandom(32'd4242));

    // reset state: ticks pass unchanged
    outcnt = 0;
    repeat (3) @(negedge clk);
    ticks();
    check("R10", outcnt, NTICK, "ticks during reset");
    @(negedge clk); rst_n = 1'b1;
    ofs_code = 8'h3F; hour_odd = 1'b0;
    visit(3, 8'h00, 1'b0, "R10");

    // sign handling
    new_hour(8'h7F, 1'b0, "R1");
    visit(1, 8'h7F, 1'b0, "R1");
    new_hour(8'h05, 1'b0, "");
    visit(4, 8'h05, 1'b0, "R4");
    visit(5, 8'h05, 1'b0, "R4");
    visit(59, 8'h05, 1'b0, "R4");

    // normal mode, odd hour: nothing; coarse in odd hour: active
    new_hour(8'h20, 1'b1, "R2");
    visit(10, 8'h20, 1'b1, "R2");
    new_hour(8'h85, 1'b1, "R3");
    visit(4, 8'h85, 1'b1, "R3");
    visit(5, 8'h85, 1'b1, "R3");
    new_hour(8'hFB, 1'b1, "R3");
    visit(2, 8'hFB, 1'b1, "R3");

    // fold into last minute
    for (int m = 60; m <= 63; m++) begin
      new_hour(8'(m), 1'b0, "");
      visit(58, 8'(m), 1'b0, "R5");
      visit(59, 8'(m), 1'b0, "R5");
    end
    new_hour(8'h40, 1'b0, "R7");
    visit(59, 8'h40, 1'b0, "R5");
    visit(30, 8'h40, 1'b0, "R7");
    new_hour(8'hC0, 1'b1, "R3");
    visit(59, 8'hC0, 1'b1, "R5");

    // mid-hour write takes effect next hour
    new_hour(8'h0A, 1'b0, "R9");
    @(negedge clk); ofs_code = 8'h03;
    visit(5, 8'h0A, 1'b0, "R9");
    visit(9, 8'h0A, 1'b0, "R9");
    visit(0, 8'h03, 1'b0, "R9");
    visit(5, 8'h03, 1'b0, "R9");

    // random hours
    for (int h = 0; h < 40; h++) begin
      c = 8'($urandom);
      o = 1'($urandom);
      new_hour(c, o, "");
      if ($urandom % 3 == 0) begin
        c2 = 8'($urandom);
        @(negedge clk); ofs_code = c2;
      end
      for (int j = 0; j < 4; j++) visit(int'($urandom % 60), c, o, "");
      visit(59, c, o, "");
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule